// File: doc/BRIEF.md
# External Interrupt Detection Controller

This block watches one non-maskable interrupt pin and twelve maskable request pins, turns activity on them into latched pending flags, and presents the single request that should reach the CPU right now. Each maskable line has its own sense mode, forwarding enable, three-bit priority level and status flag. The non-maskable line has a selectable edge, bypasses every enable and priority setting, and also sets a sticky error bit for a neighbouring transfer controller.

Software configures the block and clears flags through a small register bus. A write strobe, an address and write data are sampled on the rising clock edge, and read data is a combinational function of the address. The request outputs are plain level signals, not a stream. They describe the current winner and stay valid for as long as its flag stays pending, so there is no back-pressure to manage. The CPU acknowledges a request by clearing the flag in software.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Every pin passes through a two-flop synchronizer. A pin change driven before clock edge k shows in the status register (address 6) and on the request outputs after edge k+2, and not after edge k+1.
- R2: The sense field of line i is bits 2i+1:2i of address 2. The encodings are 00 low level, 01 falling edge, 10 rising edge and 11 both edges. Each mode sets the line's status flag (address 6, bit i) only for its own pin activity.
- R3: In low-level mode the flag is set in every cycle the synchronized pin is low. A write-one clear issued while the pin is still low leaves the flag at 1, and after the pin returns high the flag holds until it is cleared.
- R4: In an edge mode the flag stays at 1 until a write to address 6 with bit i at 1. If that clear lands in the same cycle as a new detected edge, the flag stays at 1.
- R5: Address 1 holds the detect enables: bits 11:0 for the lines and bit 12 for the non-maskable pin. When a detect enable is 0, that pin never sets its flag.
- R6: Address 3 bits 11:0 are the forwarding enables. A line whose enable is 0 still sets its status flag but is never reported on the request outputs. The request valid output is 0 when nothing enabled is pending.
- R7: Line i's level is held at address 4 bits 4i+2:4i for i below 8, and at address 5 bits 4(i-8)+2:4(i-8) for the others. Among pending enabled lines the highest level wins, and on a tie the lowest line number wins. The winner's number goes out on the 4-bit source output and its level on the level output.
- R8: Address 0 bit 0 selects the non-maskable edge: 0 selects falling, 1 selects rising. The other edge is ignored. A detected non-maskable event sets a pending flag (address 6 bit 12, write-one clear) that wins over every line regardless of enables, reporting source 12 and level 7.
- R9: The error output (also address 6 bit 13) is set by every detected non-maskable event. It is not cleared by clearing bit 12, and it returns to 0 only on a write to address 6 with bit 13 at 1.
- R10: After reset all flags, enables, detect enables and levels are 0, and the request valid and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, idle high |
| irq_pins | input | 12 | Maskable request pins, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| req_valid | output | 1 | A request is being presented |
| req_src | output | 4 | Winning source: line number, or 12 for the non-maskable pin |
| req_level | output | 3 | Winning priority level |
| nmi_err | output | 1 | Sticky error raised by a non-maskable event |

## Verification
The hardest case to reach is a software clear that lands in the same clock cycle as a newly detected edge on the same line. Reaching it means counting both synchronizer stages and the edge-history flop from the pin. The bench drives the pin on a falling clock edge, waits two more falling edges and then raises the write strobe, so that the clear and the edge detection meet on the third rising edge. The same cycle count is used to show that a pin change is not yet visible after the second edge, and the low-level hold-off is reached by issuing a clear while the pin is still low.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_IRQ = 12;
  localparam int LVL_W   = 3;
  localparam int SRC_W   = 4;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam logic [SRC_W-1:0] NMI_SRC = SRC_W'(NUM_IRQ);

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DETEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SENSE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRIO0  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PRIO1  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd6;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '1;
      end else if (g == 0) begin
        stage_q[g] <= din;
      end else begin
        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  logic   det_en,
  input  sense_e sense,
  input  logic   clr,
  output logic   hit,
  output logic   flag
);
  logic prev_q;
  logic fall, rise, det;

  always_comb begin
    fall = prev_q & ~pin_s;
    rise = ~prev_q & pin_s;
    unique case (sense)
      SENSE_LOW:  det = ~pin_s;
      SENSE_FALL: det = fall;
      SENSE_RISE: det = rise;
      default:    det = fall | rise;
    endcase
    hit = det_en & det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag   <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
  import ext_irq_pkg::*;
#(
  parameter int N = NUM_IRQ
) (
  input  logic [N-1:0]       pend,
  input  logic [N*LVL_W-1:0] lvl,
  input  logic               nmi,
  output logic               valid,
  output logic [SRC_W-1:0]   src,
  output logic [LVL_W-1:0]   level
);
  always_comb begin
    valid = 1'b0;
    src   = '0;
    level = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pend[i] && (!valid || lvl[i*LVL_W +: LVL_W] >= level)) begin
        valid = 1'b1;
        src   = SRC_W'(i);
        level = lvl[i*LVL_W +: LVL_W];
      end
    end
    if (nmi) begin
      valid = 1'b1;
      src   = NMI_SRC;
      level = '1;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nmi_pin,
  input  logic [NUM_IRQ-1:0]   irq_pins,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 req_valid,
  output logic [SRC_W-1:0]     req_src,
  output logic [LVL_W-1:0]     req_level,
  output logic                 nmi_err
);
  localparam int NPIN = NUM_IRQ + 1;
  localparam int HALF = 8;

  logic                     nmi_rise_q;
  logic [NPIN-1:0]          deten_q;
  logic [2*NUM_IRQ-1:0]     sense_q;
  logic [NUM_IRQ-1:0]       irq_en_q;
  logic [NUM_IRQ*LVL_W-1:0] prio_flat;
  logic [NPIN-1:0]          pins_s;
  logic [NPIN-1:0]          clr_vec;
  logic [NPIN-1:0]          hit_vec;
  logic [NUM_IRQ-1:0]       irq_flag;
  logic                     nmi_flag;
  logic                     err_q;
  logic                     wr_status;
  logic                     unused_wdata;

  assign unused_wdata = bus_wdata[31] ^ bus_wdata[27];
  assign wr_status    = bus_wr && (bus_addr == A_STATUS);
  assign clr_vec      = wr_status ? bus_wdata[NPIN-1:0] : '0;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_rise_q <= 1'b0;
      deten_q    <= '0;
      sense_q    <= '0;
      irq_en_q   <= '0;
      prio_flat  <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_CTRL:   nmi_rise_q <= bus_wdata[0];
        A_DETEN:  deten_q    <= bus_wdata[NPIN-1:0];
        A_SENSE:  sense_q    <= bus_wdata[2*NUM_IRQ-1:0];
        A_ENABLE: irq_en_q   <= bus_wdata[NUM_IRQ-1:0];
        A_PRIO0: begin
          for (int i = 0; i < HALF; i++)
            prio_flat[i*LVL_W +: LVL_W] <= bus_wdata[4*i +: LVL_W];
        end
        A_PRIO1: begin
          for (int i = HALF; i < NUM_IRQ; i++)
            prio_flat[i*LVL_W +: LVL_W] <= bus_wdata[4*(i-HALF) +: LVL_W];
        end
        default: ;
      endcase
    end
  end

  ext_irq_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({nmi_pin, irq_pins}),
    .dout (pins_s)
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    ext_irq_line i_line (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (pins_s[g]),
      .det_en(deten_q[g]),
      .sense (sense_e'(sense_q[2*g +: 2])),
      .clr   (clr_vec[g]),
      .hit   (hit_vec[g]),
      .flag  (irq_flag[g])
    );
  end

  ext_irq_line i_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_s (pins_s[NUM_IRQ]),
    .det_en(deten_q[NUM_IRQ]),
    .sense (nmi_rise_q ? SENSE_RISE : SENSE_FALL),
    .clr   (clr_vec[NUM_IRQ]),
    .hit   (hit_vec[NUM_IRQ]),
    .flag  (nmi_flag)
  );

  // sticky error for the transfer controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        err_q <= 1'b0;
    else if (hit_vec[NUM_IRQ])         err_q <= 1'b1;
    else if (wr_status && bus_wdata[NPIN]) err_q <= 1'b0;
  end
  assign nmi_err = err_q;

  ext_irq_arb #(.N(NUM_IRQ)) i_arb (
    .pend (irq_flag & irq_en_q),
    .lvl  (prio_flat),
    .nmi  (nmi_flag),
    .valid(req_valid),
    .src  (req_src),
    .level(req_level)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:   bus_rdata[0] = nmi_rise_q;
      A_DETEN:  bus_rdata[NPIN-1:0] = deten_q;
      A_SENSE:  bus_rdata[2*NUM_IRQ-1:0] = sense_q;
      A_ENABLE: bus_rdata[NUM_IRQ-1:0] = irq_en_q;
      A_PRIO0: begin
        for (int i = 0; i < HALF; i++)
          bus_rdata[4*i +: LVL_W] = prio_flat[i*LVL_W +: LVL_W];
      end
      A_PRIO1: begin
        for (int i = HALF; i < NUM_IRQ; i++)
          bus_rdata[4*(i-HALF) +: LVL_W] = prio_flat[i*LVL_W +: LVL_W];
      end
      A_STATUS: bus_rdata[NPIN:0] = {err_q, nmi_flag, irq_flag};
      default: ;
    endcase
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic                     req_valid,
  input logic [SRC_W-1:0]         req_src,
  input logic [LVL_W-1:0]         req_level,
  input logic                     nmi_err,
  input logic [NUM_IRQ-1:0]       flags,
  input logic [NUM_IRQ-1:0]       en,
  input logic [NUM_IRQ*LVL_W-1:0] prio,
  input logic                     nmi_pend
);
  logic [NUM_IRQ-1:0] live;
  logic               src_live;
  logic               better;
  logic               err_clr;

  assign live    = flags & en;
  assign err_clr = bus_wr && (bus_addr == A_STATUS) && bus_wdata[NUM_IRQ+1];

  always_comb begin
    src_live = 1'b0;
    better   = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (SRC_W'(i) == req_src) src_live = live[i];
      if (live[i] && (prio[i*LVL_W +: LVL_W] > req_level ||
          (prio[i*LVL_W +: LVL_W] == req_level && SRC_W'(i) < req_src)))
        better = 1'b1;
    end
  end

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (req_valid && req_src == NMI_SRC && req_level == '1)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_err && !err_clr) |=> nmi_err); // R9

  AST_SRC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !nmi_pend) |-> src_live); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!nmi_pend && live == '0)); // R6

  AST_BEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !nmi_pend) |-> !better); // R7
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .req_valid(req_valid),
  .req_src  (req_src),
  .req_level(req_level),
  .nmi_err  (nmi_err),
  .flags    (irq_flag),
  .en       (irq_en_q),
  .prio     (prio_flat),
  .nmi_pend (nmi_flag)
);

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 1'b1;
  logic [11:0] irq_pins = '1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid;
  logic [3:0]  req_src;
  logic [2:0]  req_level;
  logic        nmi_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pins(irq_pins),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .req_valid(req_valid), .req_src(req_src),
    .req_level(req_level), .nmi_err(nmi_err)
  );

  // {line[3:0], mode[1:0], start, final, expected flag}
  localparam bit [8:0] VEC [10] = '{
    {4'd0,  2'b00, 1'b1, 1'b0, 1'b1},
    {4'd1,  2'b00, 1'b1, 1'b1, 1'b0},
    {4'd2,  2'b01, 1'b1, 1'b0, 1'b1},
    {4'd3,  2'b01, 1'b0, 1'b1, 1'b0},
    {4'd4,  2'b10, 1'b0, 1'b1, 1'b1},
    {4'd5,  2'b10, 1'b1, 1'b0, 1'b0},
    {4'd6,  2'b11, 1'b1, 1'b0, 1'b1},
    {4'd7,  2'b11, 1'b0, 1'b1, 1'b1},
    {4'd8,  2'b01, 1'b1, 1'b1, 1'b0},
    {4'd11, 2'b10, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R10 reset state
    check("R10 valid", {31'd0, req_valid}, 32'd0);
    check("R10 err", {31'd0, nmi_err}, 32'd0);
    rd(3'd6, r); check("R10 status", r, 32'd0);
    rd(3'd3, r); check("R10 enable", r, 32'd0);

    wr(3'd1, 32'h1FFF);
    wr(3'd3, 32'hFFF);

    // R2 table of sense modes
    for (int k = 0; k < 10; k++) begin
      bit [8:0] v;
      int ln;
      v  = VEC[k];
      ln = int'(v[8:5]);
      wr(3'd2, 32'(v[4:3]) << (2*ln));
      irq_pins[ln] = v[2];
      idle(5);
      wr(3'd6, 32'hFFF);
      irq_pins[ln] = v[1];
      idle(3);
      rd(3'd6, r);
      check("R2 flag", {31'd0, r[ln]}, {31'd0, v[0]});
      check("R2 valid", {31'd0, req_valid}, {31'd0, v[0]});
      if (v[0]) check("R2 src", {28'd0, req_src}, 32'(ln));
      wr(3'd2, 32'd0);
      irq_pins = '1;
      idle(5);
      wr(3'd6, 32'hFFF);
    end

    // R1 latency: fall mode on line 2
    wr(3'd2, 32'h1 << 4);
    @(negedge clk); irq_pins[2] = 1'b0;
    idle(2); rd(3'd6, r);
    check("R1 not yet", {31'd0, r[2]}, 32'd0);
    idle(1); rd(3'd6, r);
    check("R1 seen", {31'd0, r[2]}, 32'd1);
    irq_pins[2] = 1'b1; idle(4);
    wr(3'd6, 32'hFFF);

    // R4 clear in the same cycle as a new edge
    @(negedge clk); irq_pins[2] = 1'b0;
    idle(2);
    bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h4;
    @(negedge clk); bus_wr = 1'b0;
    rd(3'd6, r);
    check("R4 clear vs edge", {31'd0, r[2]}, 32'd1);
    irq_pins[2] = 1'b1; idle(4);
    rd(3'd6, r);
    check("R4 sticky after pin high", {31'd0, r[2]}, 32'd1);
    wr(3'd6, 32'h4); rd(3'd6, r);
    check("R4 cleared", {31'd0, r[2]}, 32'd0);
    wr(3'd2, 32'd0);

    // R7 priority, levels: line1=2, line3=5, line9=5
    wr(3'd4, (32'd2 << 4) | (32'd5 << 12));
    wr(3'd5, 32'd5 << 4);
    irq_pins[1] = 1'b0; irq_pins[3] = 1'b0; irq_pins[9] = 1'b0;
    idle(4);
    check("R7 src tie", {28'd0, req_src}, 32'd3);
    check("R7 level", {29'd0, req_level}, 32'd5);
    wr(3'd3, 32'hFFF & ~32'h8);
    check("R6 disabled skipped", {28'd0, req_src}, 32'd9);
    rd(3'd6, r);
    check("R6 disabled still flagged", {31'd0, r[3]}, 32'd1);

    // R3 low-level clear while low
    wr(3'd6, 32'h2);
    rd(3'd6, r);
    check("R3 clear while low", {31'd0, r[1]}, 32'd1);
    irq_pins = '1; idle(4);
    rd(3'd6, r);
    check("R3 holds after high", {31'd0, r[1]}, 32'd1);
    wr(3'd6, 32'hFFF); rd(3'd6, r);
    check("R3 cleared", r, 32'd0);
    wr(3'd3, 32'hFFF);

    // R5 detect enable off for line 5
    wr(3'd1, 32'h1FFF & ~32'h20);
    irq_pins[5] = 1'b0; idle(5);
    rd(3'd6, r);
    check("R5 ignored", r, 32'd0);
    check("R5 no request", {31'd0, req_valid}, 32'd0);
    irq_pins = '1; idle(4);
    wr(3'd1, 32'h1FFF);

    // R8 / R9 non-maskable, falling selected, all enables off
    wr(3'd3, 32'd0);
    @(negedge clk); nmi_pin = 1'b0;
    idle(3);
    check("R8 valid", {31'd0, req_valid}, 32'd1);
    check("R8 src", {28'd0, req_src}, 32'd12);
    check("R8 level", {29'd0, req_level}, 32'd7);
    check("R9 err set", {31'd0, nmi_err}, 32'd1);
    wr(3'd6, 32'h1000);
    check("R9 err survives pend clear", {31'd0, nmi_err}, 32'd1);
    check("R8 pend cleared", {31'd0, req_valid}, 32'd0);
    wr(3'd6, 32'h2000);
    check("R9 err cleared", {31'd0, nmi_err}, 32'd0);
    wr(3'd0, 32'd1);
    nmi_pin = 1'b1; idle(4);
    check("R8 rising selected", {28'd0, req_src}, 32'd12);
    wr(3'd6, 32'h3000);
    nmi_pin = 1'b0; idle(4);
    check("R8 falling ignored", {31'd0, req_valid}, 32'd0);
    check("R9 no err", {31'd0, nmi_err}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule